// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Selector

This block decides the cycle on which a flyback power switch is turned back on. A sync comparator supplies a one-cycle pulse for each valley of the ringing drain voltage. A PWM comparator supplies a pulse that ends the conduction interval. The block raises a gate-on request on a chosen valley. It also tells the analog front end which pair of comparator thresholds to use.

It has two modes, chosen by the measured switching period. In the first-valley mode the switch turns on at the first valley pulse of each off interval. When the period shrinks below a fast limit, which stands for 90 kHz, the block moves to the second-valley mode. In that mode the first valley of each off interval is skipped, the threshold select moves to the low pair, and turn-on waits for the second valley. The block returns to the first-valley mode once the period reaches a slow limit, which stands for 45 kHz. Between the two limits the mode holds.

An on-time ceiling near 95 percent of a reference period bounds the duty cycle. An off-time timeout forces a turn-on if valleys stop arriving, so the converter cannot stall.

Top module: `qr_valley_sel`

## Requirements
- R1: While reset is asserted, gate_on, thr_low_sel and mode_ext are all 0.
- R2: With enable low, gate_on drops on the next clock edge and mode_ext returns to 0 on that same edge. Valley pulses then cause no turn-on.
- R3: In first-valley mode (mode_ext = 0), a valley pulse sampled while the gate is off makes gate_on 1 from that clock edge on.
- R4: The switching period is the number of clock edges from one rising edge of gate_on to the next. If a period is below FAST_LIM while in first-valley mode, mode_ext becomes 1 on the edge where gate_on rises. The first turn-on after enable rises is not measured.
- R5: If a period is FAST_LIM or more while in first-valley mode, mode_ext stays 0. In second-valley mode (mode_ext = 1), mode_ext becomes 0 at the turn-on that ends a period of SLOW_LIM or more; a shorter period leaves it at 1.
- R6: In second-valley mode, the first valley pulse of an off interval causes no turn-on. The second valley pulse turns the gate on at that edge.
- R7: thr_low_sel (1 = low threshold pair, 0 = high pair) is 1 only in second-valley mode. It goes to 1 on the edge that samples the skipped first valley and returns to 0 on the turn-on edge.
- R8: Valley pulses sampled while gate_on is 1 are ignored and do not count toward the valley skip of the following off interval.
- R9: A pwm_off pulse sampled while the gate is on makes gate_on 0 from that edge on.
- R10: If no pwm_off arrives, gate_on falls exactly MAX_ON edges after it rose. MAX_ON = PERIOD_REF * DUTY_PCT / 100.
- R11: If no accepted valley arrives, gate_on rises exactly TIMEOUT edges after the off interval began.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low holds the switch off |
| valley_pulse | input | 1 | One-cycle pulse per detected drain valley |
| pwm_off | input | 1 | One-cycle request to end the on interval |
| gate_on | output | 1 | Gate-on request to the driver |
| thr_low_sel | output | 1 | 1 selects the low sync threshold pair |
| mode_ext | output | 1 | 1 when second-valley mode is active |

## Verification
A wrong valley count shows up on gate_on. If it has been left set since the on interval, a skipped valley turns the switch on early. If it is cleared too often, the switch waits until the next valley or the timeout. Either way the error is visible within one off interval.

A wrong period count or lost valid flag shows as a mode change at the wrong turn-on. mode_ext changes only on rising gate edges, so such an error appears at the first turn-on after it happens. A stuck threshold bit can be seen on thr_low_sel in the same off interval.

// File: rtl/qr_pkg.sv
package qr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ON   = 2'd2
  } qr_state_e;
endpackage

// File: rtl/qr_interval_timer.sv
module qr_interval_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run) begin
      cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
    end
  end

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt_q == '0); // R10, R11
endmodule

// File: rtl/qr_period_meter.sv
module qr_period_meter #(
  parameter int unsigned FAST_LIM = 1111,
  parameter int unsigned SLOW_LIM = 2222
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  output logic mode_ext
);
  localparam int unsigned CW = $clog2(SLOW_LIM + 1);
  localparam int unsigned PW = CW + 1;
  localparam logic [CW-1:0] LASTC  = CW'(SLOW_LIM - 1);
  localparam logic [PW-1:0] FAST_C = PW'(FAST_LIM);
  localparam logic [PW-1:0] SLOW_C = PW'(SLOW_LIM);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          valid_q, valid_d;
  logic          mode_q, mode_d;
  logic [PW-1:0] period;

  assign period = {1'b0, cnt_q} + PW'(1);

  always_comb begin
    cnt_d   = cnt_q;
    valid_d = valid_q;
    mode_d  = mode_q;
    if (!enable) begin
      cnt_d   = '0;
      valid_d = 1'b0;
      mode_d  = 1'b0;
    end else if (start) begin
      cnt_d   = '0;
      valid_d = 1'b1;
      if (valid_q) begin
        if (!mode_q && (period < FAST_C))      mode_d = 1'b1;
        else if (mode_q && (period >= SLOW_C)) mode_d = 1'b0;
      end
    end else if (cnt_q != LASTC) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      mode_q  <= mode_d;
    end
  end

  assign mode_ext = mode_q;

  AST_NO_MODE_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !$past(mode_q)) |-> $past(valid_q)); // R4
endmodule

// File: rtl/qr_valley_ctrl.sv
module qr_valley_ctrl
  import qr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic valley_pulse,
  input  logic pwm_off,
  input  logic mode_ext,
  input  logic wait_exp,
  input  logic on_exp,
  output logic gate_on,
  output logic thr_low_sel,
  output logic start,
  output logic wait_run,
  output logic on_run
);
  qr_state_e state_q, state_d;
  logic      seen_q, seen_d;
  logic      thr_q, thr_d;
  logic      valley_ok;

  assign valley_ok = valley_pulse && (!mode_ext || seen_q);

  always_comb begin
    state_d = state_q;
    seen_d  = seen_q;
    thr_d   = thr_q;
    start   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        seen_d = 1'b0;
        thr_d  = 1'b0;
        if (enable) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!enable) begin
          state_d = ST_IDLE;
          seen_d  = 1'b0;
          thr_d   = 1'b0;
        end else if (valley_ok || wait_exp) begin
          state_d = ST_ON;
          start   = 1'b1;
          seen_d  = 1'b0;
          thr_d   = 1'b0;
        end else if (valley_pulse && mode_ext) begin
          seen_d = 1'b1;
          thr_d  = 1'b1;
        end
      end
      ST_ON: begin
        seen_d = 1'b0;
        thr_d  = 1'b0;
        if (!enable)                state_d = ST_IDLE;
        else if (pwm_off || on_exp) state_d = ST_WAIT;
      end
      default: begin
        state_d = ST_IDLE;
        seen_d  = 1'b0;
        thr_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
      thr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      thr_q   <= thr_d;
    end
  end

  assign gate_on     = (state_q == ST_ON);
  assign thr_low_sel = thr_q;
  assign wait_run    = (state_q == ST_WAIT);
  assign on_run      = (state_q == ST_ON);

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate_on); // R2
  AST_PWM_OFF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && pwm_off) |=> !gate_on); // R9
  AST_THR_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    thr_low_sel |-> !gate_on); // R7
  AST_THR_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    thr_low_sel |-> mode_ext); // R7
endmodule

// File: rtl/qr_valley_sel.sv
module qr_valley_sel #(
  parameter int unsigned FAST_LIM   = 1111,
  parameter int unsigned SLOW_LIM   = 2222,
  parameter int unsigned TIMEOUT    = 3000,
  parameter int unsigned PERIOD_REF = 2222,
  parameter int unsigned DUTY_PCT   = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic valley_pulse,
  input  logic pwm_off,
  output logic gate_on,
  output logic thr_low_sel,
  output logic mode_ext
);
  localparam int unsigned MAX_ON = (PERIOD_REF * DUTY_PCT) / 100;

  logic start;
  logic wait_run, on_run;
  logic wait_exp, on_exp;

  qr_valley_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .valley_pulse (valley_pulse),
    .pwm_off      (pwm_off),
    .mode_ext     (mode_ext),
    .wait_exp     (wait_exp),
    .on_exp       (on_exp),
    .gate_on      (gate_on),
    .thr_low_sel  (thr_low_sel),
    .start        (start),
    .wait_run     (wait_run),
    .on_run       (on_run)
  );

  qr_period_meter #(
    .FAST_LIM (FAST_LIM),
    .SLOW_LIM (SLOW_LIM)
  ) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .start    (start),
    .mode_ext (mode_ext)
  );

  qr_interval_timer #(.LIMIT(TIMEOUT)) u_off_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wait_run),
    .expire (wait_exp)
  );

  qr_interval_timer #(.LIMIT(MAX_ON)) u_on_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (on_run),
    .expire (on_exp)
  );

  AST_MODE_AT_TURNON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ext != $past(mode_ext)) |-> ((gate_on && !$past(gate_on)) || !$past(enable))); // R4
endmodule

// File: tb/qr_valley_sel_bench.sv
module qr_valley_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FAST = 40;
  localparam int SLOW = 80;
  localparam int TMO  = 100;
  localparam int REF  = 80;
  localparam int DUTY = 95;
  localparam int MAXON = REF * DUTY / 100;

  logic clk = 1'b0;
  logic rst_n, enable, valley_pulse, pwm_off;
  logic gate_on, thr_low_sel, mode_ext;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int exp_q[$];
  string tag_q[$];
  logic gate_prev = 1'b0;

  qr_valley_sel #(
    .FAST_LIM(FAST), .SLOW_LIM(SLOW), .TIMEOUT(TMO), .PERIOD_REF(REF), .DUTY_PCT(DUTY)
  ) u_qr_valley_sel (
    .clk(clk), .rst_n(rst_n), .enable(enable), .valley_pulse(valley_pulse),
    .pwm_off(pwm_off), .gate_on(gate_on), .thr_low_sel(thr_low_sel), .mode_ext(mode_ext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: each turn-on edge pops the expected cycle
  always @(negedge clk) begin
    if (gate_on && !gate_prev) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected turn-on at cycle %0d, expected none", cyc);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL %s turn-on at cycle %0d, expected %0d", t, cyc, e);
        end
      end
    end
    gate_prev = gate_on;
  end

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic valley_now(bit exp_rise, string tag);
    valley_pulse = 1'b1;
    if (exp_rise) begin
      exp_q.push_back(cyc + 1);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    valley_pulse = 1'b0;
  endtask

  task automatic valley_at(int k, bit exp_rise, string tag);
    if (k > 1) tick(k - 1);
    valley_now(exp_rise, tag);
  endtask

  task automatic off_now();
    pwm_off = 1'b1;
    @(negedge clk);
    pwm_off = 1'b0;
  endtask

  task automatic on_then_off(int len);
    if (len > 1) tick(len - 1);
    off_now();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int f;
    int s;
    rst_n = 1'b0; enable = 1'b0; valley_pulse = 1'b0; pwm_off = 1'b0;
    tick(3);
    chk("R1 gate", gate_on, 1'b0);
    chk("R1 thr", thr_low_sel, 1'b0);
    chk("R1 mode", mode_ext, 1'b0);
    rst_n = 1'b1;
    tick(2);

    // disabled: valley has no effect
    valley_now(1'b0, "R2");
    tick(2);
    chk("R2 idle gate", gate_on, 1'b0);

    enable = 1'b1;
    tick(1);
    valley_at(3, 1'b1, "R3 first turn-on");
    chk("R3 gate", gate_on, 1'b1);
    chk("R4 first not measured", mode_ext, 1'b0);

    on_then_off(10);
    chk("R9 pwm_off", gate_on, 1'b0);
    valley_at(5, 1'b1, "R3 first valley");
    chk("R4 fast period", mode_ext, 1'b1);
    chk("R7 thr at turn-on", thr_low_sel, 1'b0);

    // R8: valley during on interval is ignored
    tick(2);
    valley_now(1'b0, "R8");
    tick(6);
    off_now();
    tick(2);
    chk("R7 thr before skip", thr_low_sel, 1'b0);
    valley_at(2, 1'b0, "R6");
    chk("R6 first skipped", gate_on, 1'b0);
    chk("R8 skip still done", gate_on, 1'b0);
    chk("R7 thr low after skip", thr_low_sel, 1'b1);
    valley_at(4, 1'b1, "R6 second valley");
    chk("R7 thr cleared", thr_low_sel, 1'b0);
    chk("R5 short period in ext", mode_ext, 1'b1);

    on_then_off(20);
    valley_at(10, 1'b0, "R6");
    chk("R7 thr low", thr_low_sel, 1'b1);
    valley_at(20, 1'b1, "R6 second valley");
    chk("R5 hysteresis ext", mode_ext, 1'b1);

    on_then_off(10);
    f = cyc;
    valley_at(5, 1'b0, "R6");
    exp_q.push_back(f + TMO);
    tag_q.push_back("R11 timeout ext");
    tick(TMO - 6);
    chk("R11 not early", gate_on, 1'b0);
    tick(1);
    chk("R5 slow period", mode_ext, 1'b0);
    chk("R7 thr normal", thr_low_sel, 1'b0);

    on_then_off(20);
    valley_at(30, 1'b1, "R3 valley");
    chk("R5 hysteresis normal", mode_ext, 1'b0);

    s = cyc;
    tick(MAXON - 1);
    chk("R10 still on", gate_on, 1'b1);
    tick(1);
    chk("R10 max on", gate_on, 1'b0);
    valley_at(3, 1'b1, "R3 after ceiling");

    on_then_off(10);
    f = cyc;
    exp_q.push_back(f + TMO);
    tag_q.push_back("R11 timeout normal");
    tick(TMO);
    chk("R11 forced on", gate_on, 1'b1);

    on_then_off(5);
    valley_at(5, 1'b1, "R4 fast");
    chk("R4 back to ext", mode_ext, 1'b1);
    enable = 1'b0;
    tick(1);
    chk("R2 gate off", gate_on, 1'b0);
    chk("R2 mode cleared", mode_ext, 1'b0);
    valley_now(1'b0, "R2");
    tick(3);
    chk("R2 no turn-on", gate_on, 1'b0);

    enable = 1'b1;
    tick(1);
    valley_at(2, 1'b1, "R4 re-enable");
    chk("R4 unmeasured after enable", mode_ext, 1'b0);

    tick(2);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R3 missing turn-ons actual %0d expected 0", exp_q.size());
    end
    if (s < 0) $display("unreachable");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule